// File: doc/BRIEF.md
# Alternating-Polarity Ripple Adder/Subtractor

This block adds or subtracts two N-bit operands with a ripple carry chain. The chain is built from one mirror-style full-adder core that returns the complement of both its carry and its sum. At even bit positions the core sees the true operands and the true carry. It hands a complemented carry to the next bit, and its sum is inverted once on the way out. At odd positions the core sees complemented operands and the complemented carry from below. Because complementing all three inputs of a full adder complements both outputs, the odd core returns the true carry and the true sum directly. No inverter sits between neighbouring cells on the carry path.

Each sum bit is formed from the carry signal that its own cell already produced, rather than from a separate XOR tree. Subtraction complements every bit of B with XOR gates driven by the select line and forces the bit-0 carry-in high. Every bit also reports whether it kills, propagates or generates a carry, based on A and the B value that actually enters the adder.

The block is purely combinational and holds no state. Each output settles from the inputs that are present in the same cycle. The block has no handshake and no clock.

Top module: `adsub_alt_ripple`

## Requirements
- R1: With `sub_i`=0, `sum_o` equals (A + B) modulo 2^WIDTH.
- R2: With `sub_i`=0, `cout_o` equals bit WIDTH of the unbounded sum A + B.
- R3: With `sub_i`=1, `sum_o` equals (A − B) modulo 2^WIDTH, and `cout_o` is 1 exactly when A ≥ B as unsigned numbers.
- R4: `ovf_o` is the XOR of the true carry into the most significant bit and the true carry out of it. It is 1 exactly when the result overflows as two's-complement.
- R5: For bit i, `stat_o[2i+1:2i]` is 2'b00 (kill) when A[i] and Beff[i] are both 0, 2'b10 (generate) when both are 1, and 2'b01 (propagate) otherwise. Here Beff = B XOR {WIDTH{sub_i}}. The code 2'b11 never appears.
- R6: Cell polarity alternates from a regular cell at bit 0. For an odd WIDTH the last cell is regular, and its complemented carry is inverted once to form `cout_o`. The results of R1 to R4 hold for both odd and even WIDTH.
- R7: At WIDTH=8, with A=8'h4F, B=8'h4D and `sub_i`=0, the outputs are `sum_o`=8'h9C, `cout_o`=0 and `ovf_o`=1.
- R8: The outputs depend only on the inputs present in the same cycle. A result never depends on an earlier operand pair.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| opa_i | input | WIDTH | Operand A |
| opb_i | input | WIDTH | Operand B (the subtrahend when subtracting) |
| sub_i | input | 1 | 1 selects A − B, 0 selects A + B |
| sum_o | output | WIDTH | Result bits |
| cout_o | output | 1 | True-polarity carry out of the top bit |
| ovf_o | output | 1 | Two's-complement overflow |
| stat_o | output | 2*WIDTH | Per-bit carry status, two bits per position |

## Verification
The bench runs three widths at once: 8, 9 and 64 bits. The odd width ends on a regular cell. A design that forgot the final re-inversion there would return a complemented `cout_o` at 9 bits but not at 8 or 64. Vectors with all ones plus one, alternating patterns and equal operands under subtraction drive the carry through every cell. An inverter left in, or missing, at a cell boundary would then corrupt the sum bits above that boundary. The equal-operand case pins `cout_o`=1 for A − A, which a design with a wrong bit-0 carry-in fails. The sign-boundary vectors expose an overflow taken from the wrong carry pair. The status patterns catch a kill/generate swap and any status computed from the raw B instead of the effective B.

// File: rtl/adsub_pkg.sv
package adsub_pkg;
  typedef enum logic [1:0] {
    ST_KILL = 2'b00,
    ST_PROP = 2'b01,
    ST_GEN  = 2'b10
  } bit_stat_e;
endpackage

// File: rtl/adsub_mirror_core.sv
// Mirror-style full-adder core: returns the complement of the majority and
// the complement of the sum, the sum being derived from the carry node.
module adsub_mirror_core (
  input  logic x_i,
  input  logic y_i,
  input  logic z_i,
  output logic kn_o,
  output logic sn_o
);
  logic maj;
  always_comb begin
    maj  = (x_i & y_i) | (z_i & (x_i | y_i));
    kn_o = ~maj;
    sn_o = ~((x_i & y_i & z_i) | ((x_i | y_i | z_i) & kn_o));
  end
endmodule

// File: rtl/adsub_status.sv
module adsub_status
  import adsub_pkg::*;
(
  input  logic       a_i,
  input  logic       b_i,
  output logic [1:0] stat_o
);
  logic kill, gen;
  always_comb begin
    kill = ~a_i & ~b_i;
    gen  = a_i & b_i;
    if (kill)     stat_o = ST_KILL;
    else if (gen) stat_o = ST_GEN;
    else          stat_o = ST_PROP;
  end
endmodule

// File: rtl/adsub_slice.sv
// One bit position. INV=0: regular cell, true carry in, complemented carry out.
// INV=1: inverted cell, complemented carry in, true carry out.
module adsub_slice
  import adsub_pkg::*;
#(
  parameter bit INV = 1'b0
) (
  input  logic       a_i,
  input  logic       b_i,
  input  logic       cy_i,
  output logic       cy_o,
  output logic       sum_o,
  output logic [1:0] stat_o
);
  logic x, y, kn, sn;
  logic c_in_t, c_out_t;

  generate
    if (INV) begin : g_inv
      assign x       = ~a_i;
      assign y       = ~b_i;
      assign sum_o   = sn;
      assign c_in_t  = ~cy_i;
      assign c_out_t = kn;
    end else begin : g_reg
      assign x       = a_i;
      assign y       = b_i;
      assign sum_o   = ~sn;
      assign c_in_t  = cy_i;
      assign c_out_t = ~kn;
    end
  endgenerate

  adsub_mirror_core u_core (
    .x_i (x),
    .y_i (y),
    .z_i (cy_i),
    .kn_o(kn),
    .sn_o(sn)
  );

  assign cy_o = kn;

  adsub_status u_stat (
    .a_i   (a_i),
    .b_i   (b_i),
    .stat_o(stat_o)
  );

  // Status from the status logic must agree with the carry chain.
  always_comb begin
    if (!$isunknown({a_i, b_i, cy_i})) begin
      p_gen_sets_carry_r5: assert (stat_o != ST_GEN || c_out_t == 1'b1)
        else $error("generate status without carry out");
      p_kill_clears_carry_r5: assert (stat_o != ST_KILL || c_out_t == 1'b0)
        else $error("kill status with carry out");
      p_prop_passes_carry_r5: assert (stat_o != ST_PROP || c_out_t == c_in_t)
        else $error("propagate status did not pass carry");
      p_sum_parity_r1: assert (sum_o == (a_i ^ b_i ^ c_in_t))
        else $error("slice sum mismatch");
    end
  end
endmodule

// File: rtl/adsub_alt_ripple.sv
module adsub_alt_ripple
  import adsub_pkg::*;
#(
  parameter int WIDTH = 64
) (
  input  logic [WIDTH-1:0]   opa_i,
  input  logic [WIDTH-1:0]   opb_i,
  input  logic               sub_i,
  output logic [WIDTH-1:0]   sum_o,
  output logic               cout_o,
  output logic               ovf_o,
  output logic [2*WIDTH-1:0] stat_o
);
  localparam bit LAST_REG = (WIDTH % 2) == 1;

  logic [WIDTH-1:0] b_eff;
  logic [WIDTH:0]   chain;   // as wired: true at even index, complemented at odd
  logic [WIDTH:0]   c_true;

  assign b_eff    = opb_i ^ {WIDTH{sub_i}};
  assign chain[0] = sub_i;

  generate
    for (genvar i = 0; i < WIDTH; i++) begin : g_bit
      adsub_slice #(.INV((i % 2) == 1)) u_slice (
        .a_i   (opa_i[i]),
        .b_i   (b_eff[i]),
        .cy_i  (chain[i]),
        .cy_o  (chain[i+1]),
        .sum_o (sum_o[i]),
        .stat_o(stat_o[2*i +: 2])
      );
    end
    for (genvar k = 0; k <= WIDTH; k++) begin : g_ct
      if ((k % 2) == 1) begin : g_neg
        assign c_true[k] = ~chain[k];
      end else begin : g_pos
        assign c_true[k] = chain[k];
      end
    end
  endgenerate

  // For odd WIDTH chain[WIDTH] is complemented; g_ct undoes it once.
  assign cout_o = c_true[WIDTH];
  assign ovf_o  = c_true[WIDTH] ^ c_true[WIDTH-1];

  logic [WIDTH:0] ref_tot;
  logic           sa, sb, ss;
  always_comb begin
    ref_tot = {1'b0, opa_i} + {1'b0, b_eff} + {{WIDTH{1'b0}}, sub_i};
    sa = opa_i[WIDTH-1];
    sb = b_eff[WIDTH-1];
    ss = sum_o[WIDTH-1];
    if (!$isunknown({opa_i, opb_i, sub_i})) begin
      p_sum_ref_r1: assert ({cout_o, sum_o} == ref_tot)
        else $error("chain result differs from arithmetic sum");
      p_sub_cmp_r3: assert (!sub_i || (cout_o == (opa_i >= opb_i)))
        else $error("subtract carry is not A>=B");
      p_ovf_sign_r4: assert (ovf_o == ((sa == sb) && (ss != sa)))
        else $error("overflow flag disagrees with sign rule");
      p_last_pol_r6: assert (LAST_REG ? (cout_o == ~chain[WIDTH]) : (cout_o == chain[WIDTH]))
        else $error("carry out polarity wrong");
    end
  end

  generate
    for (genvar j = 0; j < WIDTH; j++) begin : g_chk
      always_comb begin
        p_stat_legal_r5: assert (stat_o[2*j +: 2] != 2'b11)
          else $error("illegal status code");
      end
    end
  endgenerate
endmodule

// File: tb/test_adsub_alt_ripple.sv
module test_adsub_alt_ripple;
  logic clk = 1'b0;
  logic rst = 1'b1;
  always #4 clk = ~clk;   // 125 MHz

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  logic [63:0] a64 = '0, b64 = '0;
  logic        sub = 1'b0;

  logic [63:0]  s64;  logic c64, v64; logic [127:0] st64;
  logic [8:0]   s9;   logic c9,  v9;  logic [17:0]  st9;
  logic [7:0]   s8;   logic c8,  v8;  logic [15:0]  st8;

  adsub_alt_ripple #(.WIDTH(64)) i_adsub_alt_ripple (
    .opa_i(a64), .opb_i(b64), .sub_i(sub),
    .sum_o(s64), .cout_o(c64), .ovf_o(v64), .stat_o(st64));
  adsub_alt_ripple #(.WIDTH(9)) i_adsub_alt_ripple_w9 (
    .opa_i(a64[8:0]), .opb_i(b64[8:0]), .sub_i(sub),
    .sum_o(s9), .cout_o(c9), .ovf_o(v9), .stat_o(st9));
  adsub_alt_ripple #(.WIDTH(8)) i_adsub_alt_ripple_w8 (
    .opa_i(a64[7:0]), .opb_i(b64[7:0]), .sub_i(sub),
    .sum_o(s8), .cout_o(c8), .ovf_o(v8), .stat_o(st8));

  task automatic fail_line(input string req, input string what,
                           input logic [127:0] got, input logic [127:0] exp);
    errors++;
    $display("FAIL %s %s: actual=%h expected=%h", req, what, got, exp);
  endtask

  task automatic check_w(input int w, input logic [63:0] gs, input logic gc,
                         input logic go, input logic [127:0] gst);
    logic [64:0] m, aa, bx, tot;
    logic [63:0] es;
    logic ec, eo;
    logic [127:0] est;
    m   = (65'd1 << w) - 65'd1;
    aa  = {1'b0, a64} & m;
    bx  = sub ? (~{1'b0, b64} & m) : ({1'b0, b64} & m);
    tot = aa + bx + {64'd0, sub};
    es  = tot[63:0] & m[63:0];
    ec  = tot[w];
    eo  = (aa[w-1] == bx[w-1]) && (tot[w-1] != aa[w-1]);
    est = '0;
    for (int j = 0; j < w; j++) begin
      if (aa[j] && bx[j])        est[2*j +: 2] = 2'b10;
      else if (!aa[j] && !bx[j]) est[2*j +: 2] = 2'b00;
      else                       est[2*j +: 2] = 2'b01;
    end
    checks++;
    if (gs !== es) fail_line(sub ? "R3" : "R1", $sformatf("sum w=%0d", w), {64'd0, gs}, {64'd0, es});
    checks++;
    if (gc !== ec) fail_line(w == 9 ? "R6" : (sub ? "R3" : "R2"), $sformatf("cout w=%0d", w), {127'd0, gc}, {127'd0, ec});
    if (sub) begin
      checks++;
      if (gc !== (aa >= ({1'b0, b64} & m)))
        fail_line("R3", $sformatf("A>=B w=%0d", w), {127'd0, gc}, {127'd0, aa >= ({1'b0, b64} & m)});
    end
    checks++;
    if (go !== eo) fail_line("R4", $sformatf("ovf w=%0d", w), {127'd0, go}, {127'd0, eo});
    checks++;
    if (gst !== est) fail_line("R5", $sformatf("status w=%0d", w), gst, est);
  endtask

  // R8: inputs change at posedge, outputs compared at the following negedge.
  task automatic apply(input logic [63:0] a, input logic [63:0] b, input logic s);
    @(posedge clk);
    a64 = a; b64 = b; sub = s;
    @(negedge clk);
    check_w(64, s64, c64, v64, st64);
    check_w(9, {55'd0, s9}, c9, v9, {110'd0, st9});
    check_w(8, {56'd0, s8}, c8, v8, {112'd0, st8});
  endtask

  initial begin
    repeat (3) @(posedge clk);
    rst = 1'b0;
    @(negedge clk);
    // Reset-time state: zero operands give zero sum, all-kill status (R1, R5)
    checks++;
    if (s64 !== 64'd0 || st64 !== 128'd0) fail_line("R1", "zero inputs", {64'd0, s64}, 128'd0);

    // R7 worked example
    apply(64'h4F, 64'h4D, 1'b0);
    checks++;
    if (s8 !== 8'h9C || c8 !== 1'b0 || v8 !== 1'b1)
      fail_line("R7", "example", {118'd0, c8, v8, s8}, {118'd0, 1'b0, 1'b1, 8'h9C});

    // Corner patterns, add and subtract (R1 R2 R3 R4 R6)
    for (int s = 0; s < 2; s++) begin
      apply('0, '0, s[0]);
      apply('1, '1, s[0]);
      apply('1, 64'd1, s[0]);
      apply(64'd0, 64'd1, s[0]);
      apply({32{2'b10}}, {32{2'b01}}, s[0]);
      apply({32{2'b01}}, {32{2'b01}}, s[0]);
      apply(64'h7FFF_FFFF_FFFF_FF7F, 64'h0000_0000_0000_0081, s[0]);
      apply(64'h8000_0000_0000_0180, 64'h8000_0000_0000_0180, s[0]);
      apply(64'h0123_4567_89AB_CDEF, 64'h0123_4567_89AB_CDEF, s[0]);
    end
    // R8: random sequence, each result depends only on its own operands
    for (int n = 0; n < 400; n++)
      apply({$urandom, $urandom}, {$urandom, $urandom}, n[0] ^ n[3]);

    done = 1'b1;
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(8 * 200000);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule